// File: doc/BRIEF.md
# Sinusoidal PWM Generator with Percentage Amplitude Scaling

This block produces a single sine-modulated pulse train. A phase accumulator steps through a table that holds one full period of a sine wave. The selected sample is scaled in fixed point by an amplitude given in whole percent. The scaled reference is then compared against a symmetric triangular carrier that runs freely and is centred on zero. The output is high whenever the reference lies above the carrier. Because the amplitude factor multiplies every sample, a lower percentage narrows each pulse's deviation from the half-duty point by the same ratio at every point of the cycle.

The phase accumulator advances once per carrier period, by the amount on `phase_step`. The new sample takes effect only at the carrier's lowest point, so the reference is fixed for the whole of each carrier period. The carrier may be narrower than the table samples. In that case the reference is cut down to the carrier width by an arithmetic right shift before the comparison. Dropping `en` or asserting `rst` silences the output and returns the counters to zero.

Top module: `spwm_gen`

## Requirements
- R1: The table holds 2^LUT_AW signed SAMPLE_W-bit entries covering 0 to 360 degrees. Entry i is within 4 LSB of (2^(SAMPLE_W-1)-1)·sin(2πi/2^LUT_AW).
- R2: After a restart, the carrier starts at 0 and rises by 1 per enabled cycle to +P, where P = 2^(CARRIER_W-1)-1. It then falls by 1 per cycle to -P and rises again. One carrier period is therefore 4P cycles.
- R3: The ACC_W-bit phase accumulator adds `phase_step` once per carrier period, when the carrier is at +P. `phase_idx` is the top LUT_AW bits of the accumulator value that selected the reference now in use.
- R4: `phase_idx` and the reference change only on the clock edge at which the carrier sits at -P. They are constant for the 4P cycles that follow.
- R5: The reference equals floor(sample · pct · 655 / 65536), where 655 = round(65536/100). Its latency is one register stage after the sample.
- R6: A percentage of 0 forces the reference to 0. The output is then high for exactly 2P-1 cycles of every carrier period.
- R7: An `amp_pct` value above 99 gives the same result as 99.
- R8: `pwm_out` is high exactly when the reference, arithmetically shifted right by SAMPLE_W-CARRIER_W bits, is strictly greater than the carrier. For a shifted reference R, the number of high cycles per period is clamp(R+P-1, 0, 2P) + clamp(R+P, 0, 2P).
- R9: The high time above half duty at the 45 degree index (2^LUT_AW/8) is about 0.707 times the same quantity at the 90 degree index.
- R10: While `rst` is high or `en` is low, `pwm_out` is 0 and `phase_idx` is 0. After a restart, the first `phase_idx` change is visible 3P+1 cycles after the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the block idle and cleared |
| amp_pct | input | PCT_W (7) | Amplitude in whole percent, 0 to 99; larger values are clamped |
| phase_step | input | ACC_W (16) | Phase accumulator increment per carrier period |
| pwm_out | output | 1 | Modulated pulse output |
| phase_idx | output | LUT_AW (8) | Table index of the sample behind the current reference |

## Verification
The assertions assume that reset is asserted from time zero, so the carrier, the accumulator and the pipeline registers start from defined values. They also assume that `amp_pct` is sampled only while the block runs. The bound on the scaled reference takes the table peak as its limit. The stimulus holds `rst` from the start and changes inputs only on falling clock edges. It keeps `amp_pct` and `phase_step` stable across each measured period and discards the first period after any change. Every step is a multiple of 2^(ACC_W-LUT_AW), so the index moves by an exact amount each period.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    localparam int PCT_FULL  = 100;
    localparam int PCT_MAX   = 99;
    localparam int FRAC_BITS = 16;
    // round(2^16 / 100) = 655
    localparam int SCALE_MUL = ((1 << FRAC_BITS) + PCT_FULL / 2) / PCT_FULL;

    typedef enum logic {
        SLOPE_UP   = 1'b0,
        SLOPE_DOWN = 1'b1
    } slope_e;

    // Integer rational sine approximation over one half wave, mirrored
    // negative for the second half. Error is below 0.2 percent of peak.
    function automatic int sine_point(input int idx, input int depth, input int peak);
        longint half;
        longint t;
        longint u;
        longint den;
        longint val;
        half = longint'(depth / 2);
        t    = longint'(idx) % half;
        u    = t * (half - t);
        den  = (5 * half * half) / 4 - u;
        val  = (4 * u * longint'(peak) + den / 2) / den;
        if (longint'(idx) >= half) begin
            val = -val;
        end
        return int'(val);
    endfunction

    // Largest magnitude the scaled reference may reach.
    function automatic int scaled_limit(input int peak);
        longint p;
        p = longint'(peak) * longint'(PCT_MAX) * longint'(SCALE_MUL);
        return int'(p >>> FRAC_BITS) + 1;
    endfunction

endpackage

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom
    import spwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [DATA_W-1:0] data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PEAK  = (1 << (DATA_W - 1)) - 1;

    logic signed [DATA_W-1:0] table_w [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        localparam int VAL = sine_point(gi, DEPTH, PEAK);
        assign table_w[gi] = DATA_W'(VAL);
    end

    assign data = table_w[addr];

endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier
    import spwm_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    output logic signed [CW-1:0] level,
    output logic                 at_top,
    output logic                 at_bottom
);

    localparam logic signed [CW-1:0] TOP = CW'((1 << (CW - 1)) - 1);
    localparam logic signed [CW-1:0] BOT = -TOP;

    logic signed [CW-1:0] cnt_q;
    slope_e               slope_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q   <= '0;
            slope_q <= SLOPE_UP;
        end else begin
            case (slope_q)
                SLOPE_UP: begin
                    if (cnt_q == TOP) begin
                        slope_q <= SLOPE_DOWN;
                        cnt_q   <= cnt_q - CW'(1);
                    end else begin
                        cnt_q   <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    if (cnt_q == BOT) begin
                        slope_q <= SLOPE_UP;
                        cnt_q   <= cnt_q + CW'(1);
                    end else begin
                        cnt_q   <= cnt_q - CW'(1);
                    end
                end
            endcase
        end
    end

    assign level     = cnt_q;
    assign at_top    = run && (cnt_q == TOP);
    assign at_bottom = run && (cnt_q == BOT);

    AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= TOP) && (cnt_q >= BOT)); // R2

    AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |->
            ((cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q == $past(cnt_q) - CW'(1)))); // R2

endmodule

// File: rtl/spwm_phase.sv
module spwm_phase #(
    parameter int ACC_W = 16,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             advance,
    input  logic [ACC_W-1:0] step,
    output logic [AW-1:0]    fetch_idx
);

    localparam int IDX_SHIFT = ACC_W - AW;

    logic [ACC_W-1:0] acc_q;
    logic [AW-1:0]    idx_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc_q <= '0;
            idx_q <= '0;
        end else if (advance) begin
            acc_q <= acc_q + step;
            idx_q <= AW'((acc_q + step) >> IDX_SHIFT);
        end
    end

    assign fetch_idx = idx_q;

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !advance) |=> $stable(idx_q)); // R3

endmodule

// File: rtl/spwm_scaler.sv
module spwm_scaler
    import spwm_pkg::*;
#(
    parameter int SW    = 12,
    parameter int AW    = 8,
    parameter int PCT_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 load,
    input  logic [PCT_W-1:0]     pct,
    input  logic signed [SW-1:0] sample,
    input  logic [AW-1:0]        sample_idx,
    output logic signed [SW-1:0] ref_level,
    output logic [AW-1:0]        ref_idx
);

    localparam int MUL_W = $clog2(SCALE_MUL + 1) + 1;
    localparam int PW    = SW + PCT_W + MUL_W + 1;
    localparam int PEAK  = (1 << (SW - 1)) - 1;
    localparam int LIMIT = scaled_limit(PEAK);

    typedef struct packed {
        logic [AW-1:0]        idx;
        logic signed [SW-1:0] level;
    } ref_stage_t;

    logic [PCT_W-1:0]     pct_eff;
    logic signed [PW-1:0] s_ext;
    logic signed [PW-1:0] p_ext;
    logic signed [PW-1:0] m_ext;
    logic signed [PW-1:0] prod;
    ref_stage_t           pend_q;
    ref_stage_t           live_q;

    always_comb begin
        pct_eff = (pct > PCT_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : pct;
        s_ext   = PW'(sample);
        p_ext   = $signed(PW'(pct_eff));
        m_ext   = PW'(SCALE_MUL);
        prod    = s_ext * p_ext * m_ext;
    end

    // Stage 1: scaled sample waiting for the next carrier bottom.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pend_q <= '0;
        end else begin
            pend_q.level <= SW'(prod >>> FRAC_BITS);
            pend_q.idx   <= sample_idx;
        end
    end

    // Stage 2: reference in force for one whole carrier period.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            live_q <= '0;
        end else if (load) begin
            live_q <= pend_q;
        end
    end

    assign ref_level = live_q.level;
    assign ref_idx   = live_q.idx;

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |=> $stable(live_q)); // R4

    AST_PCT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && ($past(pct) == '0)) |-> (pend_q.level == '0)); // R6

    AST_REF_BOUND: assert property (@(posedge clk) disable iff (rst)
        (int'(pend_q.level) <= LIMIT) && (int'(pend_q.level) >= -LIMIT)); // R7

endmodule

// File: rtl/spwm_gen.sv
module spwm_gen #(
    parameter int LUT_AW    = 8,
    parameter int SAMPLE_W  = 12,
    parameter int CARRIER_W = 12,
    parameter int ACC_W     = 16,
    parameter int PCT_W     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PCT_W-1:0]  amp_pct,
    input  logic [ACC_W-1:0]  phase_step,
    output logic              pwm_out,
    output logic [LUT_AW-1:0] phase_idx
);

    localparam int REF_SHIFT = SAMPLE_W - CARRIER_W;

    logic                        run;
    logic signed [CARRIER_W-1:0] carrier;
    logic                        at_top;
    logic                        at_bottom;
    logic [LUT_AW-1:0]           fetch_idx;
    logic signed [SAMPLE_W-1:0]  sample;
    logic signed [SAMPLE_W-1:0]  ref_level;
    logic signed [CARRIER_W-1:0] ref_cmp;

    assign run = en && !rst;

    spwm_carrier #(.CW(CARRIER_W)) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .level     (carrier),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    spwm_phase #(.ACC_W(ACC_W), .AW(LUT_AW)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .advance   (at_top),
        .step      (phase_step),
        .fetch_idx (fetch_idx)
    );

    spwm_sine_rom #(.ADDR_W(LUT_AW), .DATA_W(SAMPLE_W)) u_rom (
        .addr (fetch_idx),
        .data (sample)
    );

    spwm_scaler #(.SW(SAMPLE_W), .AW(LUT_AW), .PCT_W(PCT_W)) u_scaler (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .load       (at_bottom),
        .pct        (amp_pct),
        .sample     (sample),
        .sample_idx (fetch_idx),
        .ref_level  (ref_level),
        .ref_idx    (phase_idx)
    );

    if (REF_SHIFT == 0) begin : g_same_width
        assign ref_cmp = ref_level;
    end else begin : g_narrow_carrier
        assign ref_cmp = CARRIER_W'(ref_level >>> REF_SHIFT);
    end

    assign pwm_out = run && (ref_cmp > carrier);

    AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase_idx == '0)); // R10

endmodule

// File: tb/spwm_gen_bench.sv
`timescale 1ns/1ps
module spwm_gen_bench;

    localparam int AW    = 8;
    localparam int SW    = 12;
    localparam int CW    = 8;
    localparam int ACC_W = 16;
    localparam int PCT_W = 7;
    localparam int P     = (1 << (CW - 1)) - 1;
    localparam int PER   = 4 * P;
    localparam int NV    = 8;
    localparam real PI   = 3.14159265358979;

    // {pct[26:20], step[19:4], periods[3:0]}
    localparam logic [26:0] VECS [NV] = '{
        {7'd99,  16'h2000, 4'd8},
        {7'd50,  16'h1000, 4'd4},
        {7'd25,  16'h0A00, 4'd4},
        {7'd1,   16'h3000, 4'd3},
        {7'd120, 16'h2000, 4'd3},
        {7'd127, 16'h1800, 4'd3},
        {7'd0,   16'h0500, 4'd3},
        {7'd75,  16'hF000, 4'd3}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en  = 1'b0;
    logic [PCT_W-1:0] pct = '0;
    logic [ACC_W-1:0] step = '0;
    logic             pwm;
    logic [AW-1:0]    idx;

    int n_checks = 0;
    int n_fail   = 0;
    int h32 = -1;
    int h64 = -1;

    always #2 clk = ~clk;

    spwm_gen #(
        .LUT_AW(AW), .SAMPLE_W(SW), .CARRIER_W(CW), .ACC_W(ACC_W), .PCT_W(PCT_W)
    ) u_spwm_gen (
        .clk(clk), .rst(rst), .en(en), .amp_pct(pct), .phase_step(step),
        .pwm_out(pwm), .phase_idx(idx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int expect_high(input int index, input int pc);
        int     pe;
        int     samp;
        longint prod;
        int     sc;
        int     r;
        pe   = (pc > 99) ? 99 : pc;
        samp = int'(2047.0 * $sin(2.0 * PI * real'(index) / 256.0));
        prod = longint'(samp) * longint'(pe) * 64'sd655;
        sc   = int'(prod >>> 16);
        r    = sc >>> (SW - CW);
        return clampi(r + P - 1, 0, 2 * P) + clampi(r + P, 0, 2 * P);
    endfunction

    task automatic sync_boundary();
        int old;
        int k;
        old = int'(idx);
        k = 0;
        while (int'(idx) == old && k < 2 * PER) begin
            @(negedge clk);
            k++;
        end
        if (k >= 2 * PER) check(1'b0, "R3 boundary", k, PER);
    endtask

    task automatic measure(output int hi, output int id, output bit st, output int nx);
        id = int'(idx);
        hi = 0;
        st = 1'b1;
        for (int i = 0; i < PER; i++) begin
            if (pwm) hi++;
            if (int'(idx) != id) st = 1'b0;
            @(negedge clk);
        end
        nx = int'(idx);
    endtask

    task automatic restart_delay(input string tag);
        int k;
        k = 0;
        while (idx == '0 && k < 4 * PER) begin
            @(negedge clk);
            k++;
        end
        check(k == 3 * P + 1, tag, k, 3 * P + 1);
    endtask

    initial begin
        #600000;
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R10: reset state, even with enable high
        en = 1'b1;
        pct = 7'd99;
        step = 16'h2000;
        repeat (3) @(negedge clk);
        check(pwm == 1'b0, "R10 reset pwm", int'(pwm), 0);
        check(idx == '0, "R10 reset phase_idx", int'(idx), 0);
        rst = 1'b0;
        restart_delay("R10 R2 first update after reset");

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            int hi;
            int id;
            int nx;
            bit st;
            int pv;
            int sv;
            int np;
            int ex;
            int tol;
            string tg;
            pv   = int'(VECS[v][26:20]);
            sv   = int'(VECS[v][19:4]);
            np   = int'(VECS[v][3:0]);
            pct  = PCT_W'(pv);
            step = ACC_W'(sv);
            tol  = (pv == 0) ? 0 : 3;
            tg   = (pv == 0) ? "R6 R8 midscale duty" :
                   ((pv > 99) ? "R7 clamp duty" : "R1 R5 R8 duty");
            sync_boundary();
            measure(hi, id, st, nx);
            for (int k = 0; k < np; k++) begin
                measure(hi, id, st, nx);
                ex = expect_high(id, pv);
                check((hi - ex <= tol) && (ex - hi <= tol), tg, hi, ex);
                check(st, "R4 reference held in period", 0, 1);
                check(nx != id, "R2 period length", nx, (id + (sv >> 8)) % 256);
                check(nx == (id + (sv >> 8)) % 256, "R3 phase step", nx, (id + (sv >> 8)) % 256);
                if (v == 0 && id == 32) h32 = hi;
                if (v == 0 && id == 64) h64 = hi;
            end
        end

        // R9: 45 degree versus 90 degree pulse deviation
        begin
            int a32;
            int a64;
            int ex;
            a32 = h32 - (2 * P - 1);
            a64 = h64 - (2 * P - 1);
            ex  = int'(0.7071 * real'(a64));
            check((h32 >= 0) && (h64 >= 0) && (a32 - ex <= 3) && (ex - a32 <= 3),
                  "R9 45 degree ratio", a32, ex);
        end

        // R10: enable low clears and silences
        pct = 7'd99;
        step = 16'h2000;
        en = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            check(pwm == 1'b0, "R10 disabled pwm", int'(pwm), 0);
            check(idx == '0, "R10 disabled phase_idx", int'(idx), 0);
            @(negedge clk);
        end
        en = 1'b1;
        restart_delay("R10 R2 restart after enable");

        // R10: reset in the middle of a run
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(pwm == 1'b0, "R10 mid-run reset pwm", int'(pwm), 0);
        check(idx == '0, "R10 mid-run reset phase_idx", int'(idx), 0);
        rst = 1'b0;
        restart_delay("R10 restart after mid-run reset");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_fail);
        $finish;
    end

endmodule